// File: doc/BRIEF.md
# Streaming Multi-Word Flash Programmer

This block writes a run of consecutive 32-bit words into a flash array. It is built for software that supplies data faster than it can stage a whole run. Software writes a start address, the multi-word program command and four data words, then triggers the engine. The four data words form two double-word halves: half A (words 0 and 1) and half B (words 2 and 3). The engine programs the halves in turn, A first, each taking `PROG_CYCLES` clock cycles. While the engine works on one half, software refills the other.

Each half has a full flag. Software polls the flag and writes new data only once the flag shows the half is empty. If a half is still empty when the engine wants it, the engine stops cleanly and leaves the address of the first unwritten word in a current-address register. Software clears the low four bits of that address and starts again from that 16-byte boundary. A run also ends normally after 64 words or when the address reaches a 256-byte boundary.

A behavioural flash array is included. Programming can only clear bits, and a single-word read command gives software a way to read the array.

Top module: `bprog_top`

Register map (word index on `bus_waddr` / `bus_raddr`):
- 0 command
- 1 start address
- 2..5 data words 0..3
- 6 trigger: write bit 0 = 1 to start; reads back busy in bit 0
- 7 status: bit 0 fail (write 1 to clear), bit 1 busy, bit 2 half A full, bit 3 half B full
- 8 current address
- 9 read result

## Requirements
- R1: After reset the status and current-address registers read 0, and every flash word reads 32'hFFFFFFFF.
- R2: A trigger (a write of 1 to index 6) starts a run when three conditions hold: the command register holds 8'h27, the start address is 16-byte aligned, and the engine is idle. Let the trigger be taken at edge k. From edge k the engine is busy and both full flags are set. Half A is programmed at the start address at edge k+P, and half B 8 bytes higher at edge k+2P. The halves then alternate, each 8 bytes above the last (P = `PROG_CYCLES`).
- R3: A half's full flag clears at the edge where that half is written to flash. While busy, writing the half's second word sets the flag again: index 3 for half A, index 5 for half B.
- R4: While busy, a write to a data word of a half whose full flag is set is ignored.
- R5: When a half finishes and the other half is not full, the run ends at that same edge. Busy clears, fail stays 0, and the current address holds the address of the first unwritten word.
- R6: A run ends normally once 64 words are written or the next address lies on a 256-byte boundary. The current address then points one word past the last word programmed, and no word beyond it changes.
- R7: A trigger with command 8'h27 and a start address whose low 4 bits are not 0 sets the fail bit, does not start the engine and programs nothing. Writing 1 to status bit 0 clears the fail bit.
- R8: Programming a flash word stores the bitwise AND of the old and new values. A trigger with command 8'h00 while idle loads the word at the start address into the read-result register at that edge.
- R9: Starting again from the stop address with its low 4 bits cleared, using the matching data, leaves the whole intended range with the intended contents.
- R10: A trigger written while busy is ignored. The run continues at its original addresses, and the new start address is not programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 4 | Register write index |
| bus_wdata | input | 32 | Register write data |
| bus_raddr | input | 4 | Register read index |
| bus_rdata | output | 32 | Register read data, combinational from `bus_raddr` |

## Verification
Register writes take effect at the next rising edge, and reads are combinational. Every value is therefore sampled one unit after a falling edge, and the state seen there is the state after the edge just passed.

Taking the trigger edge as k, the bench samples the status at k+P-1 and k+P to see half A's flag drop on time. It samples again at k+2P-1 and k+2P to see the run end on a starved half exactly at the half boundary. The current address is read once the engine is idle, and flash contents are read back through the read command after each run.

// File: rtl/bprog_pkg.sv
package bprog_pkg;

    // register indices
    localparam logic [3:0] RG_CMD  = 4'd0;
    localparam logic [3:0] RG_ADDR = 4'd1;
    localparam logic [3:0] RG_D0   = 4'd2;
    localparam logic [3:0] RG_D1   = 4'd3;
    localparam logic [3:0] RG_D2   = 4'd4;
    localparam logic [3:0] RG_D3   = 4'd5;
    localparam logic [3:0] RG_TRIG = 4'd6;
    localparam logic [3:0] RG_STAT = 4'd7;
    localparam logic [3:0] RG_CUR  = 4'd8;
    localparam logic [3:0] RG_RDAT = 4'd9;

    // command codes
    localparam logic [7:0] CMD_READ  = 8'h00;
    localparam logic [7:0] CMD_MPROG = 8'h27;

    // status bit positions
    localparam int ST_FAIL  = 0;
    localparam int ST_BUSY  = 1;
    localparam int ST_FULLA = 2;
    localparam int ST_FULLB = 3;

    typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} seq_state_e;

    // one double-word write towards the array
    typedef struct packed {
        logic        we;
        logic [31:0] lo;
        logic [31:0] hi;
    } dword_wr_t;

    function automatic logic is_aligned16(input logic [3:0] low_bits);
        return low_bits == 4'd0;
    endfunction

endpackage

// File: rtl/bprog_flash.sv
module bprog_flash
    import bprog_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int FLASH_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  dword_wr_t         wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ADDR_W-1:0] raddr,
    output logic [31:0]       rdata
);
    localparam int IDX_W = $clog2(FLASH_WORDS);

    logic [31:0]      cells [FLASH_WORDS];
    logic [IDX_W-1:0] w_even;
    logic [IDX_W-1:0] w_odd;
    logic [IDX_W-1:0] r_idx;
    logic             unused_bits;

    assign w_even      = {waddr[IDX_W+1:3], 1'b0};
    assign w_odd       = {waddr[IDX_W+1:3], 1'b1};
    assign r_idx       = raddr[IDX_W+1:2];
    assign unused_bits = ^{waddr[2:0], raddr[1:0]};
    assign rdata       = cells[r_idx];

    // programming can only clear bits
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FLASH_WORDS; i++) cells[i] <= '1;
        end else if (wr.we) begin
            cells[w_even] <= cells[w_even] & wr.lo;
            cells[w_odd]  <= cells[w_odd]  & wr.hi;
        end
    end

endmodule

// File: rtl/bprog_seq.sv
module bprog_seq
    import bprog_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PROG_CYCLES = 8,
    parameter int BURST_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [7:0]        cmd,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        full,
    output logic              busy,
    output logic              start,
    output logic              fail_set,
    output logic              pair_done,
    output logic              pair_sel,
    output logic              run_end,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int CNT_W     = $clog2(PROG_CYCLES + 1);
    localparam int BLK_W     = $clog2(BURST_BYTES);
    localparam int MAX_WORDS = BURST_BYTES / 4;
    localparam int WC_W      = $clog2(MAX_WORDS + 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WC_W-1:0]   words_q;
    logic [WC_W-1:0]   words_next;
    logic              pair_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] next_addr;
    logic              accept;
    logic              hit_end;
    logic              starved;

    assign busy       = (state_q == SQ_RUN);
    assign accept     = go && !busy && (cmd == CMD_MPROG);
    assign start      = accept && is_aligned16(start_addr[3:0]);
    assign fail_set   = accept && !is_aligned16(start_addr[3:0]);
    assign pair_done  = busy && (cnt_q == CNT_W'(PROG_CYCLES - 1));
    assign next_addr  = addr_q + ADDR_W'(8);
    assign words_next = words_q + WC_W'(2);
    assign hit_end    = (next_addr[BLK_W-1:0] == '0) || (words_next == WC_W'(MAX_WORDS));
    assign starved    = !full[~pair_q];
    assign run_end    = pair_done && (hit_end || starved);
    assign pair_sel   = pair_q;
    assign cur_addr   = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            words_q <= '0;
            pair_q  <= 1'b0;
            addr_q  <= '0;
        end else if (start) begin
            state_q <= SQ_RUN;
            cnt_q   <= '0;
            words_q <= '0;
            pair_q  <= 1'b0;
            addr_q  <= start_addr;
        end else if (busy) begin
            if (pair_done) begin
                addr_q  <= next_addr;
                words_q <= words_next;
                cnt_q   <= '0;
                pair_q  <= ~pair_q;
                if (run_end) state_q <= SQ_IDLE;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/bprog_regs.sv
module bprog_regs
    import bprog_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [3:0]        bus_waddr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_raddr,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              start,
    input  logic              fail_set,
    input  logic              pair_done,
    input  logic              pair_sel,
    input  logic              run_end,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [31:0]       flash_rdata,
    output logic              go,
    output logic [7:0]        cmd,
    output logic [ADDR_W-1:0] start_addr,
    output logic [3:0][31:0]  data_words,
    output logic [1:0]        full,
    output logic              fail
);
    logic [7:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       word_q [4];
    logic              full_q [2];
    logic              fail_q;
    logic [31:0]       rdat_q;

    assign go = bus_wr && (bus_waddr == RG_TRIG) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
            fail_q <= 1'b0;
            rdat_q <= '0;
        end else begin
            if (bus_wr && bus_waddr == RG_CMD)  cmd_q  <= bus_wdata[7:0];
            if (bus_wr && bus_waddr == RG_ADDR) addr_q <= bus_wdata[ADDR_W-1:0];
            if (fail_set) fail_q <= 1'b1;
            else if (bus_wr && bus_waddr == RG_STAT && bus_wdata[ST_FAIL]) fail_q <= 1'b0;
            if (go && !busy && cmd_q == CMD_READ) rdat_q <= flash_rdata;
        end
    end

    // data words: a full half is locked while the engine runs
    for (genvar gw = 0; gw < 4; gw++) begin : g_word
        localparam int HALF = gw / 2;
        always_ff @(posedge clk) begin
            if (rst) word_q[gw] <= '0;
            else if (bus_wr && bus_waddr == 4'(RG_D0 + gw) && !(busy && full_q[HALF]))
                word_q[gw] <= bus_wdata;
        end
        assign data_words[gw] = word_q[gw];
    end

    // per-half full flags
    for (genvar gp = 0; gp < 2; gp++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) full_q[gp] <= 1'b0;
            else if (start) full_q[gp] <= 1'b1;
            else if (run_end || (pair_done && pair_sel == gp[0])) full_q[gp] <= 1'b0;
            else if (bus_wr && busy && !full_q[gp] && bus_waddr == 4'(RG_D1 + 2 * gp))
                full_q[gp] <= 1'b1;
        end
        assign full[gp] = full_q[gp];
    end

    assign cmd        = cmd_q;
    assign start_addr = addr_q;
    assign fail       = fail_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_raddr)
            RG_CMD:  bus_rdata = 32'(cmd_q);
            RG_ADDR: bus_rdata = 32'(addr_q);
            RG_D0:   bus_rdata = word_q[0];
            RG_D1:   bus_rdata = word_q[1];
            RG_D2:   bus_rdata = word_q[2];
            RG_D3:   bus_rdata = word_q[3];
            RG_TRIG: bus_rdata = 32'(busy);
            RG_STAT: begin
                bus_rdata[ST_FAIL]  = fail_q;
                bus_rdata[ST_BUSY]  = busy;
                bus_rdata[ST_FULLA] = full_q[0];
                bus_rdata[ST_FULLB] = full_q[1];
            end
            RG_CUR:  bus_rdata = 32'(cur_addr);
            RG_RDAT: bus_rdata = rdat_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bprog_top.sv
module bprog_top
    import bprog_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int FLASH_WORDS = 1024,
    parameter int PROG_CYCLES = 8,
    parameter int BURST_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [3:0]  bus_waddr,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_raddr,
    output logic [31:0] bus_rdata
);
    logic              go;
    logic [7:0]        cmd;
    logic [ADDR_W-1:0] start_addr;
    logic [3:0][31:0]  data_words;
    logic [31:0]       data_w0;
    logic [1:0]        full;
    logic              fail;
    logic              busy;
    logic              start;
    logic              fail_set;
    logic              pair_done;
    logic              pair_sel;
    logic              run_end;
    logic [ADDR_W-1:0] cur_addr;
    logic [31:0]       flash_rdata;
    dword_wr_t         fl_wr;

    assign data_w0  = data_words[0];
    assign fl_wr.we = pair_done;
    assign fl_wr.lo = pair_sel ? data_words[2] : data_words[0];
    assign fl_wr.hi = pair_sel ? data_words[3] : data_words[1];

    bprog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .busy(busy), .start(start), .fail_set(fail_set),
        .pair_done(pair_done), .pair_sel(pair_sel), .run_end(run_end),
        .cur_addr(cur_addr), .flash_rdata(flash_rdata),
        .go(go), .cmd(cmd), .start_addr(start_addr),
        .data_words(data_words), .full(full), .fail(fail)
    );

    bprog_seq #(
        .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .BURST_BYTES(BURST_BYTES)
    ) u_seq (
        .clk(clk), .rst(rst), .go(go), .cmd(cmd), .start_addr(start_addr),
        .full(full), .busy(busy), .start(start), .fail_set(fail_set),
        .pair_done(pair_done), .pair_sel(pair_sel), .run_end(run_end),
        .cur_addr(cur_addr)
    );

    bprog_flash #(.ADDR_W(ADDR_W), .FLASH_WORDS(FLASH_WORDS)) u_flash (
        .clk(clk), .rst(rst), .wr(fl_wr), .waddr(cur_addr),
        .raddr(start_addr), .rdata(flash_rdata)
    );

endmodule

// File: rtl/bprog_chk.sv
module bprog_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              start,
    input logic              fail_set,
    input logic              fail,
    input logic              pair_done,
    input logic              pair_sel,
    input logic              run_end,
    input logic [1:0]        full,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [31:0]       data_w0,
    input logic              bus_wr,
    input logic [3:0]        bus_waddr
);
    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        start |=> busy && full == 2'b11);

    a_r2_halves_alternate: assert property (@(posedge clk) disable iff (rst)
        (pair_done && !run_end) |=> pair_sel != $past(pair_sel));

    a_r2_step_eight: assert property (@(posedge clk) disable iff (rst)
        pair_done |=> cur_addr == $past(cur_addr) + ADDR_W'(8));

    a_r3_half_a_clears: assert property (@(posedge clk) disable iff (rst)
        (pair_done && !pair_sel) |=> !full[0]);

    a_r3_half_b_clears: assert property (@(posedge clk) disable iff (rst)
        (pair_done && pair_sel) |=> !full[1]);

    a_r4_locked_word: assert property (@(posedge clk) disable iff (rst)
        (busy && full[0] && bus_wr && bus_waddr == 4'd2) |=> $stable(data_w0));

    a_r5_end_idle: assert property (@(posedge clk) disable iff (rst)
        run_end |=> !busy);

    a_r7_reject: assert property (@(posedge clk) disable iff (rst)
        fail_set |=> fail && !busy);

endmodule

bind bprog_top bprog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .start(start), .fail_set(fail_set),
    .fail(fail), .pair_done(pair_done), .pair_sel(pair_sel), .run_end(run_end),
    .full(full), .cur_addr(cur_addr), .data_w0(data_w0),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr)
);

// File: tb/tb_bprog_top.sv
module tb_bprog_top;
    import bprog_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [1024];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bprog_top #(.PROG_CYCLES(P)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_raddr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic flash_rd(input logic [31:0] a, output logic [31:0] v);
        wr(RG_ADDR, a);
        wr(RG_CMD, 32'(CMD_READ));
        wr(RG_TRIG, 32'd1);
        rd(RG_RDAT, v);
    endtask

    function automatic logic [31:0] pat(input int seed, input int i);
        return (32'h1357_0000 * seed) ^ (32'h0001_0203 * i) ^ 32'hC3A5_5A3C;
    endfunction

    task automatic model_prog(input int a, input logic [31:0] v);
        model[a >> 2] = model[a >> 2] & v;
    endtask

    task automatic verify(input string tag, input int a, input int n);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            flash_rd(a + 4 * i, v);
            chk(tag, v, model[(a >> 2) + i]);
        end
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        int t = 0;
        forever begin
            rd(RG_TRIG, v);
            if (!v[0]) break;
            @(negedge clk);
            t++;
            if (t > 2000) begin
                chk({tag, " idle timeout"}, v, 32'd0);
                break;
            end
        end
    endtask

    // load four words and trigger
    task automatic launch(input int a, input int seed, input int first);
        wr(RG_CMD, 32'(CMD_MPROG));
        wr(RG_ADDR, a);
        for (int i = 0; i < 4; i++) wr(4'(RG_D0 + i), pat(seed, first + i));
        wr(RG_TRIG, 32'd1);
    endtask

    task automatic wait_empty(input int half, input string tag);
        logic [31:0] v;
        int t = 0;
        forever begin
            rd(RG_STAT, v);
            if (!v[ST_FULLA + half]) break;
            @(negedge clk);
            t++;
            if (t > 2000) begin
                chk({tag, " refill timeout"}, v, 32'd0);
                break;
            end
        end
    endtask

    // full streaming run of n words, refilling as halves empty
    task automatic stream(input int a, input int seed, input int first, input int n, input string tag);
        for (int i = 0; i < n; i++) model_prog(a + 4 * i, pat(seed, first + i));
        launch(a, seed, first);
        for (int idx = 4; idx < n; idx += 2) begin
            int half = (idx / 2) % 2;
            wait_empty(half, tag);
            wr(4'(RG_D0 + 2 * half), pat(seed, first + idx));
            wr(4'(RG_D1 + 2 * half), pat(seed, first + idx + 1));
        end
        wait_idle(tag);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(RG_STAT, v); chk("R1 status after reset", v, 32'd0);
        rd(RG_CUR, v);  chk("R1 current address after reset", v, 32'd0);
        rd(RG_TRIG, v); chk("R1 busy after reset", v, 32'd0);
        verify("R1 erased flash", 32'h0, 2);
        verify("R1 erased flash high", 32'hFFC, 1);
    endtask

    task automatic t_full_run;
        logic [31:0] v;
        stream(32'h100, 1, 0, 64, "R6 full run");
        rd(RG_CUR, v);  chk("R6 current address after 64 words", v, 32'h200);
        rd(RG_STAT, v); chk("R6 status after normal end", v, 32'd0);
        verify("R2 R6 64-word contents", 32'h100, 64);
        verify("R6 word past run untouched", 32'h200, 1);
    endtask

    task automatic t_timing;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) model_prog(32'h300 + 4 * i, pat(2, i));
        launch(32'h300, 2, 0);
        rd(RG_STAT, v); chk("R2 status right after trigger", v, 32'hE);
        repeat (P - 1) @(negedge clk);
        rd(RG_STAT, v); chk("R3 half A still full at k+P-1", v, 32'hE);
        @(negedge clk);
        rd(RG_STAT, v); chk("R3 half A cleared at k+P", v, 32'hA);
        repeat (P - 1) @(negedge clk);
        rd(RG_STAT, v); chk("R5 still busy at k+2P-1", v, 32'hA);
        @(negedge clk);
        rd(RG_STAT, v); chk("R5 stopped at k+2P, no fail", v, 32'h0);
        rd(RG_CUR, v);  chk("R5 stop address", v, 32'h310);
        verify("R2 four words programmed", 32'h300, 4);
        verify("R5 next word untouched", 32'h310, 1);
    endtask

    task automatic t_short;
        logic [31:0] v;
        stream(32'h1E0, 3, 0, 8, "R6 boundary run");
        rd(RG_CUR, v); chk("R6 stop at 256-byte boundary", v, 32'h200);
        verify("R6 boundary run contents", 32'h1E0, 8);
        verify("R6 nothing past boundary", 32'h200, 1);
    endtask

    task automatic t_and;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) model_prog(32'h1E0 + 4 * i, pat(4, i));
        launch(32'h1E0, 4, 0);
        wait_idle("R8 reprogram");
        rd(RG_CUR, v); chk("R5 stop after reprogram", v, 32'h1F0);
        verify("R8 AND of old and new", 32'h1E0, 4);
    endtask

    task automatic t_misaligned;
        logic [31:0] v;
        wr(RG_CMD, 32'(CMD_MPROG));
        wr(RG_ADDR, 32'h704);
        wr(RG_TRIG, 32'd1);
        rd(RG_STAT, v); chk("R7 fail set, not busy", v, 32'h1);
        repeat (3 * P) @(negedge clk);
        rd(RG_CUR, v);  chk("R7 current address unchanged", v, 32'h1F0);
        verify("R7 nothing programmed", 32'h700, 4);
        wr(RG_STAT, 32'h1);
        rd(RG_STAT, v); chk("R7 fail cleared by write 1", v, 32'h0);
    endtask

    task automatic t_ignore;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) model_prog(32'h500 + 4 * i, pat(5, i));
        launch(32'h500, 5, 0);
        wr(RG_D2, 32'h0000_0000);
        wr(RG_D0, 32'h0000_0000);
        wr(RG_ADDR, 32'h600);
        wr(RG_TRIG, 32'd1);
        wait_idle("R10 retrigger");
        rd(RG_CUR, v); chk("R10 run kept its addresses", v, 32'h510);
        verify("R4 locked words kept original data", 32'h500, 4);
        verify("R10 new start address not programmed", 32'h600, 2);
    endtask

    task automatic t_resume;
        logic [31:0] v;
        logic [31:0] resume;
        for (int i = 0; i < 6; i++) model_prog(32'h400 + 4 * i, pat(6, i));
        launch(32'h400, 6, 0);
        wait_empty(0, "R9 first pass");
        wr(RG_D0, pat(6, 4));
        wr(RG_D1, pat(6, 5));
        wait_idle("R9 first pass");
        rd(RG_CUR, v); chk("R5 stop mid-block address", v, 32'h418);
        verify("R5 six words done", 32'h400, 6);
        resume = v & ~32'hF;
        stream(int'(resume), 6, 4, 60, "R9 resume");
        rd(RG_CUR, v); chk("R9 resumed run end address", v, 32'h500);
        verify("R9 whole range after resume", 32'h400, 64);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_run();
        t_timing();
        t_short();
        t_and();
        t_misaligned();
        t_ignore();
        t_resume();
        finish_run();
    end

endmodule